// File: doc/BRIEF.md
# Isolated Real-Time-Clock Command Core

This block is the always-powered side of a real-time clock that sits behind an isolation boundary. It holds a 32-bit base value, a seconds counter and two 32-bit software flag words. Software reaches it through a small word-addressed register file. Command bits are set in a 16-bit control word, and write data is staged as two 16-bit halves. The core carries out a command only when an isolation-enable strobe arrives from outside. That strobe is asynchronous to the bus clock, so it passes through a flop synchroniser and its rising edge is detected. Each rising edge causes exactly one action.

The reported time is the stored base plus the counter. To set the time, software loads the base, clears the counter, and then writes 1 to soft flag 0 to mark the clock as valid. Read commands copy a selected 32-bit value into a read-data pair. Reading the counter is a two-step operation. An arm bit in a second control word is taken on a strobe, and a later write to a trigger word copies the live counter into a snapshot pair. The counter advances on a one-second tick input that is also asynchronous and is synchronised in the same way.

Top module: `rtc_iso_core`

## Requirements
- R1: After reset, every readable word (addresses 0 to 8) reads 0. A read command for soft flag 0 (control bit 7) then returns 0.
- R2: When control bit 1 is set, a strobe loads the base with {word 4 (high half), word 3 (low half)}.
- R3: When control bit 2 is set, a strobe copies the base into the read pair (word 5 low, word 6 high). Control bit 7 does the same for soft flag 0, and control bit 8 for soft flag 1.
- R4: The counter increases by exactly one on each rising edge of the seconds tick.
- R5: When control bit 3 is set, a strobe clears the counter to zero.
- R6: When control bit 5 is set, a strobe loads soft flag 0 from the staged write pair. Control bit 6 does the same for soft flag 1, and both bits may act on the same strobe.
- R7: A command acts once per rising edge of the strobe, however long the strobe and the command bit stay high.
- R8: When several groups are set on one strobe, only the highest-priority group acts. The order is counter clear, then base write, then flag writes, then reads. Among reads, the base comes first, then flag 0, then flag 1.
- R9: A strobe with bit 0 of word 1 set arms the snapshot. A later write of bit 0 = 1 to word 2 copies the counter into the snapshot pair (word 7 low, word 8 high) and disarms it. A trigger that arrives while the snapshot is not armed leaves the snapshot unchanged.
- R10: Control bits that are set and cleared again with no strobe in between have no effect on the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_strobe | input | 1 | Asynchronous isolation-enable strobe |
| sec_tick | input | 1 | Asynchronous one-second tick |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Read data for bus_addr (combinational) |

## Verification
The assertions check on every cycle that a detected strobe or tick edge is a single-cycle pulse, and that a clear command forces the counter to zero on the next cycle. They also check that a base write loads the staged pair, that a tick adds exactly one, and that the read pair and the snapshot hold their values when no command or trigger is active. Some behaviour can only be shown by the bench's scenarios: the priority among command groups when several bits are set together, a single action while the strobe is held high across later ticks, the rejection of a trigger that was not armed, and a command bit that is withdrawn before any strobe arrives.

// File: rtl/rtc_iso_pkg.sv
package rtc_iso_pkg;
   // word addresses
   localparam int unsigned A_CTL    = 0;
   localparam int unsigned A_CTL2   = 1;
   localparam int unsigned A_TRIG   = 2;
   localparam int unsigned A_WD_LO  = 3;
   localparam int unsigned A_WD_HI  = 4;
   localparam int unsigned A_RD_LO  = 5;
   localparam int unsigned A_RD_HI  = 6;
   localparam int unsigned A_SN_LO  = 7;
   localparam int unsigned A_SN_HI  = 8;
   // control word bit positions
   localparam int unsigned B_BASE_WR = 1;
   localparam int unsigned B_BASE_RD = 2;
   localparam int unsigned B_CNT_CLR = 3;
   localparam int unsigned B_F0_WR   = 5;
   localparam int unsigned B_F1_WR   = 6;
   localparam int unsigned B_F0_RD   = 7;
   localparam int unsigned B_F1_RD   = 8;

   typedef enum logic [2:0] {
      ACT_NONE, ACT_CLR, ACT_BASE_WR, ACT_FLAG_WR,
      ACT_RD_BASE, ACT_RD_F0, ACT_RD_F1
   } rtc_act_e;
endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= async_in;
   end

   generate
      for (genvar i = 1; i <= STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   // synchronised level is chain[STAGES-1]; chain[STAGES] is its history
   assign rise = chain[STAGES-1] & ~chain[STAGES];

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_iso_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [HALF_W-1:0] bus_wdata,
   output logic [HALF_W-1:0] bus_rdata,
   output logic [HALF_W-1:0] ctl,
   output logic              arm_req,
   output logic [WORD_W-1:0] wd_word,
   output logic              trig,
   input  logic [WORD_W-1:0] rd_word,
   input  logic [WORD_W-1:0] snap_word
);
   logic [HALF_W-1:0] ctl2_q, wd_lo_q, wd_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl     <= '0;
         ctl2_q  <= '0;
         wd_lo_q <= '0;
         wd_hi_q <= '0;
      end else if (bus_we) begin
         case (int'(bus_addr))
            A_CTL:   ctl     <= bus_wdata;
            A_CTL2:  ctl2_q  <= bus_wdata;
            A_WD_LO: wd_lo_q <= bus_wdata;
            A_WD_HI: wd_hi_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign arm_req = ctl2_q[0];
   assign wd_word = {wd_hi_q, wd_lo_q};
   assign trig    = bus_we && (int'(bus_addr) == A_TRIG) && bus_wdata[0];

   always_comb begin
      case (int'(bus_addr))
         A_CTL:   bus_rdata = ctl;
         A_CTL2:  bus_rdata = ctl2_q;
         A_WD_LO: bus_rdata = wd_lo_q;
         A_WD_HI: bus_rdata = wd_hi_q;
         A_RD_LO: bus_rdata = rd_word[HALF_W-1:0];
         A_RD_HI: bus_rdata = rd_word[WORD_W-1:HALF_W];
         A_SN_LO: bus_rdata = snap_word[HALF_W-1:0];
         A_SN_HI: bus_rdata = snap_word[WORD_W-1:HALF_W];
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
   import rtc_iso_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   localparam int unsigned WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic              tick,
   input  logic [HALF_W-1:0] ctl,
   input  logic              arm_req,
   input  logic [WORD_W-1:0] wd_word,
   input  logic              trig,
   output logic [WORD_W-1:0] rd_word,
   output logic [WORD_W-1:0] snap_word
);
   logic [WORD_W-1:0] base_q, cnt_q, flag0_q, flag1_q;
   logic              armed_q;
   rtc_act_e          act;

   // priority: clear > base write > flag writes > reads
   always_comb begin
      if      (ctl[B_CNT_CLR])                act = ACT_CLR;
      else if (ctl[B_BASE_WR])                act = ACT_BASE_WR;
      else if (ctl[B_F0_WR] || ctl[B_F1_WR])  act = ACT_FLAG_WR;
      else if (ctl[B_BASE_RD])                act = ACT_RD_BASE;
      else if (ctl[B_F0_RD])                  act = ACT_RD_F0;
      else if (ctl[B_F1_RD])                  act = ACT_RD_F1;
      else                                    act = ACT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         flag0_q <= '0;
         flag1_q <= '0;
         rd_word <= '0;
      end else if (strobe) begin
         case (act)
            ACT_BASE_WR: base_q <= wd_word;
            ACT_FLAG_WR: begin
               if (ctl[B_F0_WR]) flag0_q <= wd_word;
               if (ctl[B_F1_WR]) flag1_q <= wd_word;
            end
            ACT_RD_BASE: rd_word <= base_q;
            ACT_RD_F0:   rd_word <= flag0_q;
            ACT_RD_F1:   rd_word <= flag1_q;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (strobe && act == ACT_CLR)  cnt_q <= '0;
      else if (tick)                      cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         snap_word <= '0;
      end else if (strobe && arm_req) begin
         armed_q <= 1'b1;
      end else if (trig && armed_q) begin
         snap_word <= cnt_q;
         armed_q   <= 1'b0;
      end
   end

   a_r5_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && ctl[B_CNT_CLR]) |=> (cnt_q == '0));
   a_r2_base_load: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && ctl[B_BASE_WR] && !ctl[B_CNT_CLR]) |=> (base_q == $past(wd_word)));
   a_r4_tick_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(strobe && ctl[B_CNT_CLR])) |=> (cnt_q == $past(cnt_q) + 1'b1));
   a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(rd_word));
   a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !trig |=> $stable(snap_word));
endmodule

// File: rtl/rtc_iso_core.sv
module rtc_iso_core #(
   parameter int unsigned HALF_W      = 16,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iso_strobe,
   input  logic              sec_tick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [HALF_W-1:0] bus_wdata,
   output logic [HALF_W-1:0] bus_rdata
);
   localparam int unsigned WORD_W = 2 * HALF_W;

   generate
      if (HALF_W < 9) begin : g_bad_half
         $error("rtc_iso_core: HALF_W must hold control bit 8");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("rtc_iso_core: ADDR_W must reach word 8");
      end
   endgenerate

   logic              strobe_rise, tick_rise, arm_req, trig;
   logic [HALF_W-1:0] ctl;
   logic [WORD_W-1:0] wd_word, rd_word, snap_word;

   rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
      .clk(clk), .rst_n(rst_n), .async_in(iso_strobe), .rise(strobe_rise));

   rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
      .clk(clk), .rst_n(rst_n), .async_in(sec_tick), .rise(tick_rise));

   rtc_regfile #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl(ctl),
      .arm_req(arm_req), .wd_word(wd_word), .trig(trig),
      .rd_word(rd_word), .snap_word(snap_word));

   rtc_core #(.HALF_W(HALF_W)) u_core (
      .clk(clk), .rst_n(rst_n), .strobe(strobe_rise), .tick(tick_rise),
      .ctl(ctl), .arm_req(arm_req), .wd_word(wd_word), .trig(trig),
      .rd_word(rd_word), .snap_word(snap_word));
endmodule

// File: tb/sim_rtc_iso_core.sv
module sim_rtc_iso_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iso_strobe = 1'b0;
   logic        sec_tick = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   rtc_iso_core u0 (
      .clk(clk), .rst_n(rst_n), .iso_strobe(iso_strobe), .sec_tick(sec_tick),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata));

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = 4'(a);
      #1 d = bus_rdata;
   endtask

   task automatic rd32(input int a, output logic [31:0] d);
      logic [15:0] lo, hi;
      rd(a, lo);
      rd(a + 1, hi);
      d = {hi, lo};
   endtask

   task automatic stage(input logic [31:0] v);
      wr(3, v[15:0]);
      wr(4, v[31:16]);
   endtask

   task automatic strobe();
      @(negedge clk); iso_strobe = 1'b1;
      repeat (5) @(negedge clk);
      iso_strobe = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk); sec_tick = 1'b1;
      repeat (4) @(negedge clk);
      sec_tick = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // issue one command through the control word and a strobe
   task automatic cmd(input logic [15:0] c);
      wr(0, c);
      strobe();
      wr(0, 16'h0);
   endtask

   task automatic read_cmd(input logic [15:0] c, output logic [31:0] v);
      cmd(c);
      rd32(5, v);
   endtask

   task automatic snapshot(output logic [31:0] v);
      wr(1, 16'h1);
      strobe();
      wr(1, 16'h0);
      wr(2, 16'h1);
      rd32(7, v);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      logic [31:0] v;
      for (int a = 0; a <= 8; a++) begin
         rd(a, d);
         check("R1 reset word", {16'h0, d}, 32'h0);
      end
      read_cmd(16'h0080, v);
      check("R1 flag0 after reset", v, 32'h0);
   endtask

   task automatic t_no_strobe();
      logic [31:0] v;
      stage(32'h1234_5678);
      wr(0, 16'h0002);
      repeat (6) @(negedge clk);
      wr(0, 16'h0000);
      read_cmd(16'h0004, v);
      check("R10 base untouched without strobe", v, 32'h0);
   endtask

   task automatic t_base();
      logic [31:0] v;
      cmd(16'h0002);
      read_cmd(16'h0004, v);
      check("R2 R3 base write then read", v, 32'h1234_5678);
   endtask

   task automatic t_flags();
      logic [31:0] v;
      stage(32'h0000_0001);
      cmd(16'h0020);
      stage(32'hCAFE_0000);
      cmd(16'h0040);
      read_cmd(16'h0080, v);
      check("R6 R3 flag0", v, 32'h0000_0001);
      read_cmd(16'h0100, v);
      check("R6 R3 flag1", v, 32'hCAFE_0000);
      stage(32'h0000_00AB);
      cmd(16'h0060);
      read_cmd(16'h0080, v);
      check("R6 both flags flag0", v, 32'h0000_00AB);
      read_cmd(16'h0100, v);
      check("R6 both flags flag1", v, 32'h0000_00AB);
   endtask

   task automatic t_counter();
      logic [31:0] v;
      repeat (3) tick();
      snapshot(v);
      check("R4 R9 three ticks", v, 32'd3);
      repeat (2) tick();
      wr(2, 16'h1);
      rd32(7, v);
      check("R9 unarmed trigger ignored", v, 32'd3);
      snapshot(v);
      check("R4 five ticks", v, 32'd5);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      cmd(16'h0008);
      snapshot(v);
      check("R5 counter cleared", v, 32'd0);
      // hold strobe and clear bit high across two ticks
      wr(0, 16'h0008);
      @(negedge clk); iso_strobe = 1'b1;
      repeat (6) @(negedge clk);
      tick();
      tick();
      iso_strobe = 1'b0;
      repeat (4) @(negedge clk);
      wr(0, 16'h0);
      snapshot(v);
      check("R7 one clear per strobe edge", v, 32'd2);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      stage(32'hAAAA_5555);
      cmd(16'h000A);
      read_cmd(16'h0004, v);
      check("R8 clear beats base write", v, 32'h1234_5678);
      snapshot(v);
      check("R8 clear acted", v, 32'd0);
      stage(32'h0000_0BAD);
      cmd(16'h0022);
      read_cmd(16'h0080, v);
      check("R8 base write beats flag write", v, 32'h0000_00AB);
      read_cmd(16'h0004, v);
      check("R8 base written", v, 32'h0000_0BAD);
      stage(32'h0000_0077);
      cmd(16'h00A0);
      rd32(5, v);
      check("R8 flag write beats read", v, 32'h0000_0BAD);
      read_cmd(16'h0184, v);
      check("R8 base read beats flag reads", v, 32'h0000_0BAD);
      read_cmd(16'h0180, v);
      check("R8 flag0 read beats flag1 read", v, 32'h0000_0077);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_no_strobe();
      t_base();
      t_flags();
      t_counter();
      t_clear();
      t_priority();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule